// File: doc/BRIEF.md
# Pipelined Burst Synchronous Memory

This block is a behavioural model of a synchronous pipelined burst memory. Each word is 32 bits wide and can be written one byte at a time. An access starts when either of two address strobes is sampled low: one strobe comes from the processor side and one from the controller side. On that edge the block loads the external address. After that, the block advances a two-bit burst count by itself, so a host can walk through four words while sending a single address. A mode pin chooses between two burst orders. In XOR-interleaved order, the low address bits are the start bits XOR the beat number. In linear order, the low address bits are the start bits plus the beat number, wrapping modulo four.

On every clock the block classifies the cycle from its control pins. The cycle can be a deselect, the beginning of a burst, a continuation that moves to the next burst address, a suspension that uses the current address again, or an idle cycle. The write controls then decide whether the access reads or writes. Read data is registered. The bus driver is gated by an asynchronous output enable, shown here as a data output with a separate drive-enable pin.

The sleep input is asynchronous. It passes through a two-stage synchronizer, stops accepting accesses and keeps the stored contents. When sleep is released, a short recovery window follows, and accesses presented during that window are ignored. Address width sets the depth: with the address width at 16 the array holds 64K words.

Top module: `burst_sram`

## Requirements
- R1: With `mode_intl`=1, beat k of a burst (k=0..3, beat 0 is the begin cycle) uses the low address bits start[1:0] XOR k.
- R2: With `mode_intl`=0, beat k uses the low address bits (start[1:0] + k) modulo 4.
- R3: A cycle with `adsp_n` or `adsc_n` low is a deselect when the chip is not selected. The chip is selected only when `ce_n`=0, `ce2`=1 and `ce3_n`=0. A deselect cycle makes no access, turns `dq_oe` off on the next edge and ends the burst, so a later continue cycle with no new begin does nothing.
- R4: A cycle with either strobe low while the chip is selected begins a burst at `addr`, using either strobe. The cycle is a write if `gw_n`=0, or if `bwe_n`=0 with at least one `bw_n` bit low. Otherwise it is a read.
- R5: When both strobes are high and a burst is active, `adv_n`=0 moves to the next beat. `adv_n`=1 suspends the burst and accesses the same address again.
- R6: On a write, `gw_n`=0 writes all four bytes whatever `bwe_n` and `bw_n` are. Otherwise byte i (bits 8i+7..8i) is written only when `bwe_n`=0 and `bw_n[i]`=0, and the other bytes keep their contents.
- R7: `dq_oe` is high only while read data is held and `oe_n` is low. `oe_n` acts combinationally, without waiting for a clock edge.
- R8: Read data for an access accepted on a clock edge appears on `dq_o`, with `dq_oe` high, from that edge until the next one.
- R9: `zz` is synchronized through two flops. While the memory sleeps, accesses are ignored, any burst is dropped and stored contents are kept.
- R10: After the synchronized sleep input falls, a recovery window of two cycles follows in which strobes are ignored. The first access accepted afterwards reads the contents from before sleep.
- R11: Address bits above bit 1 keep the value loaded at the begin cycle for every beat of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control state |
| zz | input | 1 | Asynchronous sleep request, active high |
| mode_intl | input | 1 | 1 selects interleaved burst order, 0 selects linear |
| ce_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends the burst |
| gw_n | input | 1 | Global write, active low, writes all bytes |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 4 | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | External word address |
| dq_i | input | 32 | Write data |
| dq_o | output | 32 | Read data |
| dq_oe | output | 1 | Drive enable for the data bus; low means high impedance |

## Verification
Some rules are checked by assertions on every clock. These cover the step between consecutive burst addresses in both orders, the fixed upper address bits within a burst, the bus turning off after a deselect, the drive enable being gated by the output enable, the burst ending during sleep, and the length of the recovery window. Other behaviour can only be shown by the bench's scenarios, because it needs the stored data itself. That includes the full beat order from every start address, the suspend repeats, byte masks merging with older contents, writes attempted during sleep or recovery leaving the memory unchanged, and the pipelined read returning the right word.

// File: rtl/sbp_pkg.sv
`timescale 1ns/1ps
package sbp_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_DESEL,
        CYC_BEGIN,
        CYC_CONT,
        CYC_SUSP
    } cyc_e;

    typedef enum logic [1:0] {
        PWR_AWAKE,
        PWR_SLEEP,
        PWR_RECOV
    } pwr_e;

    // low two address bits for a given beat of a burst
    function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       intl);
        return intl ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/sbp_cycle_dec.sv
`timescale 1ns/1ps
module sbp_cycle_dec
    import sbp_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic             ce_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [BYTES-1:0] bw_n,
    input  logic             burst_act,
    output cyc_e             cyc,
    output logic             wr,
    output logic [BYTES-1:0] be
);

    logic sel;
    logic strobe;

    always_comb begin
        sel    = !ce_n && ce2 && !ce3_n;
        strobe = !adsp_n || !adsc_n;

        if (strobe) begin
            cyc = sel ? CYC_BEGIN : CYC_DESEL;
        end else if (!burst_act) begin
            cyc = CYC_IDLE;
        end else begin
            cyc = adv_n ? CYC_SUSP : CYC_CONT;
        end

        if (!gw_n) begin
            be = '1;
        end else if (!bwe_n) begin
            be = ~bw_n;
        end else begin
            be = '0;
        end
        wr = |be;
    end

endmodule

// File: rtl/sbp_burst_ctr.sv
`timescale 1ns/1ps
module sbp_burst_ctr
    import sbp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  cyc_e              cyc_i,
    input  logic              intl_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              act_o,
    output logic              acc_en_o,
    output logic [ADDR_W-1:0] acc_addr_o
);

    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        acc_en_o   = 1'b0;
        acc_addr_o = {st_q.base[ADDR_W-1:2], beat_lo(st_q.base[1:0], st_q.cnt, intl_i)};

        if (!en_i) begin
            st_d.act = 1'b0;
        end else begin
            case (cyc_i)
                CYC_DESEL: begin
                    st_d.act = 1'b0;
                end
                CYC_BEGIN: begin
                    st_d.act   = 1'b1;
                    st_d.base  = addr_i;
                    st_d.cnt   = 2'd0;
                    acc_en_o   = 1'b1;
                    acc_addr_o = addr_i;
                end
                CYC_CONT: begin
                    st_d.cnt   = st_q.cnt + 2'd1;
                    acc_en_o   = 1'b1;
                    acc_addr_o = {st_q.base[ADDR_W-1:2], beat_lo(st_q.base[1:0], st_d.cnt, intl_i)};
                end
                CYC_SUSP: begin
                    acc_en_o = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o = st_q.act;

    // checker state: last address accessed
    logic [ADDR_W-1:0] last_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (acc_en_o) begin
            last_q <= acc_addr_o;
        end
    end

    // R11
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_o && cyc_i != CYC_BEGIN) |-> acc_addr_o[ADDR_W-1:2] == last_q[ADDR_W-1:2]);

    // R2
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_o && cyc_i == CYC_CONT && !intl_i) |-> acc_addr_o[1:0] == last_q[1:0] + 2'd1);

    // R1
    intl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_o && cyc_i == CYC_CONT && intl_i) |-> acc_addr_o[1:0] != last_q[1:0]);

    // R5
    susp_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_o && cyc_i == CYC_SUSP) |-> acc_addr_o == last_q);

    // R9
    sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !act_o);

endmodule

// File: rtl/sbp_sleep_ctl.sv
`timescale 1ns/1ps
module sbp_sleep_ctl
    import sbp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RECOV_CYC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zz_i,
    output logic ok_o
);

    localparam int CW = $clog2(RECOV_CYC + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        pwr_e                   pwr;
        logic [CW-1:0]          rcnt;
    } slp_t;

    slp_t st_d, st_q;
    logic zz_s;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], zz_i};
        zz_s      = st_q.sync[SYNC_STAGES-1];

        case (st_q.pwr)
            PWR_AWAKE: begin
                if (zz_s) st_d.pwr = PWR_SLEEP;
            end
            PWR_SLEEP: begin
                if (!zz_s) begin
                    st_d.pwr  = PWR_RECOV;
                    st_d.rcnt = CW'(RECOV_CYC - 1);
                end
            end
            PWR_RECOV: begin
                if (zz_s) begin
                    st_d.pwr = PWR_SLEEP;
                end else if (st_q.rcnt == '0) begin
                    st_d.pwr = PWR_AWAKE;
                end else begin
                    st_d.rcnt = st_q.rcnt - 1'b1;
                end
            end
            default: st_d.pwr = PWR_SLEEP;
        endcase

        ok_o = (st_q.pwr == PWR_AWAKE) && !zz_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // checker: count cycles spent recovering
    logic [CW:0] rec_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_run_q <= '0;
        end else if (st_q.pwr == PWR_RECOV) begin
            rec_run_q <= rec_run_q + 1'b1;
        end else begin
            rec_run_q <= '0;
        end
    end

    // R10
    rec_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pwr == PWR_RECOV) |-> (rec_run_q < (CW+1)'(RECOV_CYC)));

    // R9
    sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pwr == PWR_SLEEP) |-> !ok_o);

endmodule

// File: rtl/sbp_array.sv
`timescale 1ns/1ps
module sbp_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              rd_i,
    input  logic [DATA_W/8-1:0] be_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              rvld_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int BYTES = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t st_d, st_q;
    logic [DATA_W-1:0] word_rd;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [7:0] lane_q [DEPTH];
        always_ff @(posedge clk) begin
            if (we_i && be_i[g]) begin
                lane_q[addr_i] <= wdata_i[g*8 +: 8];
            end
        end
        assign word_rd[g*8 +: 8] = lane_q[addr_i];
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_i;
        if (rd_i) begin
            st_d.data = word_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rvld_o  = st_q.vld;
    assign rdata_o = st_q.data;

    // R8
    rd_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !we_i) |=> rvld_o);

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
    import sbp_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int RECOV_CYC   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                zz,
    input  logic                mode_intl,
    input  logic                ce_n,
    input  logic                ce2,
    input  logic                ce3_n,
    input  logic                adsp_n,
    input  logic                adsc_n,
    input  logic                adv_n,
    input  logic                gw_n,
    input  logic                bwe_n,
    input  logic [DATA_W/8-1:0] bw_n,
    input  logic                oe_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   dq_i,
    output logic [DATA_W-1:0]   dq_o,
    output logic                dq_oe
);

    localparam int BYTES = DATA_W / 8;

    cyc_e              cyc;
    logic              wr;
    logic [BYTES-1:0]  be;
    logic              act;
    logic              ok;
    logic              acc_en;
    logic [ADDR_W-1:0] acc_addr;
    logic              arr_we;
    logic              arr_rd;
    logic              rvld;

    sbp_cycle_dec #(.BYTES(BYTES)) dec_i (
        .ce_n      (ce_n),
        .ce2       (ce2),
        .ce3_n     (ce3_n),
        .adsp_n    (adsp_n),
        .adsc_n    (adsc_n),
        .adv_n     (adv_n),
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bw_n      (bw_n),
        .burst_act (act),
        .cyc       (cyc),
        .wr        (wr),
        .be        (be)
    );

    sbp_sleep_ctl #(.SYNC_STAGES(SYNC_STAGES), .RECOV_CYC(RECOV_CYC)) slp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .zz_i  (zz),
        .ok_o  (ok)
    );

    sbp_burst_ctr #(.ADDR_W(ADDR_W)) ctr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ok),
        .cyc_i      (cyc),
        .intl_i     (mode_intl),
        .addr_i     (addr),
        .act_o      (act),
        .acc_en_o   (acc_en),
        .acc_addr_o (acc_addr)
    );

    assign arr_we = acc_en && wr;
    assign arr_rd = acc_en && !wr;

    sbp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (arr_we),
        .rd_i    (arr_rd),
        .be_i    (be),
        .addr_i  (acc_addr),
        .wdata_i (dq_i),
        .rvld_o  (rvld),
        .rdata_o (dq_o)
    );

    // output enable is asynchronous: gated without a register
    assign dq_oe = rvld && !oe_n;

    // R3
    desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_DESEL) |=> !rvld);

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !oe_n);

endmodule

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

    localparam int AW = 10;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic zz = 1'b0;
    logic intl = 1'b0;
    logic ce_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0] bw_n = 4'hf;
    logic oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [31:0] dq_i = '0;
    logic [31:0] dq_o;
    logic dq_oe;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] mdl [DEPTH];
    logic [AW-1:0] cur_a;
    logic [1:0]    cur_b;

    always #2.5 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .zz(zz), .mode_intl(intl),
        .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    function automatic logic [1:0] exp_lo(input logic [1:0] s, input logic [1:0] k, input logic il);
        int v;
        if (il) return s ^ k;
        v = (int'(s) + int'(k)) % 4;
        return v[1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic quiet();
        ce_n = 1; ce2 = 0; ce3_n = 1; adsp_n = 1; adsc_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; bw_n = 4'hf;
    endtask

    task automatic desel();
        quiet();
        adsc_n = 0;
        oe_n = 0;
        tick();
    endtask

    // kind: 0 begin, 1 continue, 2 suspend
    task automatic beat(input int kind, input bit wr, input bit gw, input logic [3:0] bwn,
                        input bit use_p, input string req);
        logic [AW-1:0] ea;
        logic [31:0] wd;
        quiet();
        ce_n = 0; ce2 = 1; ce3_n = 0;
        if (kind == 0) begin
            if (use_p) adsp_n = 0; else adsc_n = 0;
            addr = cur_a;
            cur_b = 2'd0;
        end else if (kind == 1) begin
            adv_n = 0;
            cur_b = cur_b + 2'd1;
        end
        ea = {cur_a[AW-1:2], exp_lo(cur_a[1:0], cur_b, intl)};
        if (wr) begin
            gw_n = !gw;
            bwe_n = gw ? 1'b1 : 1'b0;
            bw_n = bwn;
            wd = $urandom;
            dq_i = wd;
            oe_n = 1;
            for (int i = 0; i < 4; i++)
                if (gw || !bwn[i]) mdl[ea][i*8 +: 8] = wd[i*8 +: 8];
        end else begin
            oe_n = 0;
        end
        tick();
        if (!wr) chk(dq_oe && dq_o === mdl[ea], req, {dq_oe, dq_o}, {1'b1, mdl[ea]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] keep;
        logic [AW-1:0] xa;
        void'($urandom(32'h5eed_1234));
        quiet();
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R7 reset state: bus released
        chk(dq_oe == 1'b0, "R7 reset", {32'd0, dq_oe}, 33'd0);

        // fill whole array with gw bursts (R6)
        intl = 0;
        for (int b = 0; b < DEPTH; b += 4) begin
            cur_a = AW'(b);
            beat(0, 1, 1, 4'hf, 0, "R6");
            for (int k = 1; k < 4; k++) beat(1, 1, 1, 4'hf, 0, "R6");
        end
        desel();

        // R1, R2, R4, R8, R11: every start in both orders
        for (int m = 0; m < 2; m++) begin
            intl = m[0];
            for (int s = 0; s < 4; s++) begin
                cur_a = AW'(10'h2c0 + s);
                beat(0, 0, 0, 4'hf, m[0], "R4");
                for (int k = 1; k < 4; k++) beat(1, 0, 0, 4'hf, 0, m ? "R1 R11" : "R2 R11");
                desel();
            end
        end

        // R5 suspend holds the address
        intl = 1;
        cur_a = 10'h1b6;
        beat(0, 0, 0, 4'hf, 0, "R8");
        beat(1, 0, 0, 4'hf, 0, "R5");
        beat(2, 0, 0, 4'hf, 0, "R5 suspend");
        beat(2, 0, 0, 4'hf, 0, "R5 suspend");
        beat(1, 0, 0, 4'hf, 0, "R5 resume");
        desel();

        // R6 byte mask, then global write overriding bw_n
        intl = 0;
        cur_a = 10'h055;
        beat(0, 1, 0, 4'b1010, 0, "R6");
        desel();
        beat(0, 0, 0, 4'hf, 0, "R6 byte mask");
        desel();
        beat(0, 1, 1, 4'hf, 0, "R6");
        desel();
        beat(0, 0, 0, 4'hf, 1, "R6 global");
        // bwe_n low with all bw_n high is a read (R4)
        quiet(); ce_n = 0; ce2 = 1; ce3_n = 0; adsc_n = 0; addr = cur_a;
        bwe_n = 0; bw_n = 4'hf; oe_n = 0; dq_i = 32'hdead_beef;
        tick();
        chk(dq_oe && dq_o === mdl[cur_a], "R4 no-byte write reads", {dq_oe, dq_o}, {1'b1, mdl[cur_a]});

        // R3 deselect mid-burst, continue afterwards ignored, write controls ignored
        cur_a = 10'h300;
        beat(0, 0, 0, 4'hf, 0, "R3");
        quiet(); ce_n = 0; ce2 = 0; ce3_n = 0; adsc_n = 0; gw_n = 0; addr = cur_a;
        dq_i = 32'h1234_5678; oe_n = 0;
        tick();
        chk(dq_oe == 1'b0, "R3 deselect releases bus", {32'd0, dq_oe}, 33'd0);
        quiet(); adv_n = 0; oe_n = 0;
        tick();
        chk(dq_oe == 1'b0, "R3 continue after deselect", {32'd0, dq_oe}, 33'd0);
        beat(0, 0, 0, 4'hf, 0, "R3 deselect wrote nothing");
        desel();

        // R7 asynchronous output enable
        cur_a = 10'h3f1;
        beat(0, 0, 0, 4'hf, 0, "R7");
        quiet(); adv_n = 1; ce_n = 0; ce2 = 1; ce3_n = 0; oe_n = 1;
        tick();
        chk(dq_oe == 1'b0, "R7 oe_n high", {32'd0, dq_oe}, 33'd0);
        #1 oe_n = 0;
        #0.5;
        chk(dq_oe && dq_o === mdl[cur_a], "R7 oe_n async low", {dq_oe, dq_o}, {1'b1, mdl[cur_a]});
        #0.5 oe_n = 1;
        #0.5;
        chk(dq_oe == 1'b0, "R7 oe_n async high", {32'd0, dq_oe}, 33'd0);
        @(negedge clk);
        desel();

        // R9 sleep: deselected, idle, then sleep
        xa = 10'h123;
        keep = mdl[xa];
        quiet(); tick();
        zz = 1;
        repeat (3) begin quiet(); tick(); end
        repeat (3) begin
            quiet(); ce_n = 0; ce2 = 1; ce3_n = 0; adsc_n = 0; gw_n = 0;
            addr = xa; dq_i = $urandom; oe_n = 1;
            tick();
        end
        quiet(); ce_n = 0; ce2 = 1; ce3_n = 0; adsc_n = 0; addr = xa; oe_n = 0;
        tick();
        chk(dq_oe == 1'b0, "R9 read in sleep ignored", {32'd0, dq_oe}, 33'd0);
        // R10 release and strike during recovery
        zz = 0;
        repeat (4) begin
            quiet(); ce_n = 0; ce2 = 1; ce3_n = 0; adsc_n = 0; gw_n = 0;
            addr = xa; dq_i = $urandom; oe_n = 1;
            tick();
        end
        repeat (3) begin quiet(); tick(); end
        cur_a = xa;
        beat(0, 0, 0, 4'hf, 0, "R10 contents kept");
        chk(mdl[xa] === keep, "R9 model untouched", {1'b0, mdl[xa]}, {1'b0, keep});
        desel();

        // random bursts
        for (int it = 0; it < 300; it++) begin
            bit w;
            bit g;
            logic [3:0] bm;
            intl = $urandom_range(0, 1);
            cur_a = AW'($urandom);
            w = $urandom_range(0, 1);
            g = $urandom_range(0, 1);
            bm = 4'($urandom_range(0, 14));
            beat(0, w, g, bm, $urandom_range(0, 1), intl ? "R1" : "R2");
            for (int k = 1; k < 4; k++) begin
                if ($urandom_range(0, 3) == 0) beat(2, w, g, bm, 0, "R5");
                beat(1, w, g, bm, 0, intl ? "R1" : "R2");
            end
            desel();
            if (w) begin
                beat(0, 0, 0, 4'hf, 0, "R6 random readback");
                for (int k = 1; k < 4; k++) beat(1, 0, 0, 4'hf, 0, "R6 random readback");
                desel();
            end
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule